// File: doc/BRIEF.md
# MDIO Management Master with Command Word

This block is a management-interface master for Ethernet PHYs. Software controls it through a single 32-bit command word. One write of that word holds everything a frame needs: the go bit, the frame-type code, the operation code, the PHY port address, the register or device address, and 16 bits of data. When the go bit is set, the block shifts out one complete management frame on the MDC/MDIO pins. It then clears the go bit to show it has finished. After a read frame, the block places the 16 bits it captured from the PHY in the low half of the same word.

The frame type comes from the command word. A start code of 01 produces an ordinary Clause 22 frame. A start code of 00 produces a Clause 45 frame. In that case the 5-bit register field names the device (MMD), and the data field carries either a register address or write data. A full Clause 45 access takes two commands from software: an address-set frame first, then a write or read frame to the same port and device. Software must wait for the go bit to clear before issuing each one.

MDC is made from the system clock by a divider. The master moves MDIO only on a falling MDC edge and samples MDIO only on a rising edge. The register port is plain control and status, with no back-pressure. A write is either taken at once or ignored.

Top module: `mdio_cmd_master`

## Requirements
- R1: Writing a word with bit 31 set, while bit 31 of the readback is clear, starts one frame. Bit 31 reads back as 1 from the next cycle until the frame's last MDC falling edge, when it returns to 0.
- R2: A register write that arrives while bit 31 of the readback is set is ignored. The frame in progress, and every field of the readback, stay as they were.
- R3: Each frame is 64 bits sent MSB first. It consists of 32 ones, then command bits 17:16 (start code), then bits 19:18 (opcode), then bits 24:20 (port address), then bits 29:25 (register or device address).
- R4: For opcode 01 (write) and opcode 00 (Clause 45 address-set), the master drives the turnaround bits as 1 then 0. It then drives command bits 15:0, MSB first.
- R5: For opcode 10 (Clause 22 read) and opcode 11 (Clause 45 read), the master releases MDIO (output enable low) for both turnaround bits and all 16 data bits. It samples 16 bits on MDC rising edges, MSB first. It writes them to readback bits 15:0 in the same cycle that bit 31 clears.
- R6: After a write or address-set frame, readback bits 15:0 keep the written value, whatever the MDIO input did during the frame.
- R7: MDC has a period of 2*DIV_HALF system clocks while a frame runs and is held low when idle. MDIO output and output enable change only on falling MDC edges.
- R8: Start code 00 frames work back to back. An address-set frame followed by a write frame, or by a read frame, produces the R3–R5 layout with the device address in the register-address slot.
- R9: After reset, the readback is 0, MDC is low and the MDIO output enable is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Command register write strobe |
| reg_wdata | input | 32 | Command word to write |
| reg_rdata | output | 32 | Command word readback (busy bit 31, read data 15:0) |
| mdc | output | 1 | Management clock to PHYs |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable (1 = master drives) |
| mdio_i | input | 1 | MDIO input value from the pin |

## Verification
The bench targets the turnaround window first. A master that keeps driving during a read turnaround, or that releases the line one bit too late, shows a wrong output-enable pattern at bits 46–47. It also targets the first and last data bits of a read. A design that is off by one bit in its sampling returns the PHY's data shifted by one place.

The bench also tests writes issued while busy. A design that accepted such a write would either corrupt the readback fields or send a frame with mixed fields. A PHY model that drives data during write frames catches a design that overwrites the written data with the line value. Finally, the bench times MDC and runs both two-frame Clause 45 sequences, so a wrong divider or a device address placed in the wrong slot shows up.

// File: rtl/mdio_cmd_pkg.sv
package mdio_cmd_pkg;
  // Command word field positions (software-visible layout)
  localparam int GO_BIT   = 31;
  localparam int REG_HI   = 29;
  localparam int REG_LO   = 25;
  localparam int PHY_HI   = 24;
  localparam int PHY_LO   = 20;
  localparam int OP_HI    = 19;
  localparam int OP_LO    = 18;
  localparam int ST_HI    = 17;
  localparam int ST_LO    = 16;
  localparam int DATA_W   = 16;
  localparam int CMD_W    = 32;
  // Bits after the preamble: st(2) op(2) phy(5) reg(5) ta(2) data(16)
  localparam int BODY_LEN = 32;
  localparam int HDR_LEN  = 14;

  typedef enum logic [1:0] {
    OP_ADDR   = 2'b00,
    OP_WRITE  = 2'b01,
    OP_RD_C22 = 2'b10,
    OP_RD_C45 = 2'b11
  } mdio_op_e;

  function automatic logic op_is_read(input logic [1:0] op);
    return op[1];
  endfunction
endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
  parameter int DIV_HALF = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic mdc,
  output logic rise_tick,
  output logic fall_tick
);
  localparam int CW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV_HALF - 1);

  logic [CW-1:0] cnt_q;
  logic          mdc_q;
  logic          wrap;

  assign wrap      = en && (cnt_q == LAST);
  assign rise_tick = wrap && !mdc_q;
  assign fall_tick = wrap && mdc_q;
  assign mdc       = mdc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (!en) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (wrap) begin
      cnt_q <= '0;
      mdc_q <= ~mdc_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  AST_MDC_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !mdc_q) else $error("mdc not low when idle"); // R7
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_cmd_pkg::*;
#(
  parameter int PRE_LEN = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CMD_W-1:0]  cmd,
  input  logic              mdc,
  input  logic              rise_tick,
  input  logic              fall_tick,
  input  logic              mdio_i,
  output logic              active,
  output logic              done,
  output logic              done_rd,
  output logic [DATA_W-1:0] rd_data,
  output logic              mdio_o,
  output logic              mdio_oe
);
  localparam int FRAME_LEN = PRE_LEN + BODY_LEN;
  localparam int IW        = $clog2(FRAME_LEN);
  localparam logic [IW-1:0] TA_POS   = IW'(PRE_LEN + HDR_LEN);
  localparam logic [IW-1:0] DATA_POS = IW'(PRE_LEN + HDR_LEN + 2);
  localparam logic [IW-1:0] LAST_POS = IW'(FRAME_LEN - 1);

  logic [FRAME_LEN-1:0] frame_q;
  logic [IW-1:0]        idx_q;
  logic                 act_q;
  logic                 rd_q;
  logic [DATA_W-1:0]    shreg_q;
  logic                 last_bit;

  assign last_bit = (idx_q == LAST_POS);
  assign active   = act_q;
  assign done     = act_q && fall_tick && last_bit;
  assign done_rd  = rd_q;
  assign rd_data  = shreg_q;
  assign mdio_o   = act_q && frame_q[FRAME_LEN-1];
  assign mdio_oe  = act_q && !(rd_q && (idx_q >= TA_POS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q <= '0;
      idx_q   <= '0;
      act_q   <= 1'b0;
      rd_q    <= 1'b0;
      shreg_q <= '0;
    end else if (start) begin
      frame_q <= {{PRE_LEN{1'b1}}, cmd[ST_HI:ST_LO], cmd[OP_HI:OP_LO],
                  cmd[PHY_HI:PHY_LO], cmd[REG_HI:REG_LO], 2'b10,
                  cmd[DATA_W-1:0]};
      idx_q   <= '0;
      act_q   <= 1'b1;
      rd_q    <= op_is_read(cmd[OP_HI:OP_LO]);
    end else if (act_q) begin
      if (rise_tick && rd_q && (idx_q >= DATA_POS))
        shreg_q <= {shreg_q[DATA_W-2:0], mdio_i};
      if (fall_tick) begin
        if (last_bit) begin
          act_q <= 1'b0;
        end else begin
          idx_q   <= idx_q + 1'b1;
          frame_q <= {frame_q[FRAME_LEN-2:0], 1'b0};
        end
      end
    end
  end

  AST_MDIO_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    mdc |-> ($stable(mdio_o) && $stable(mdio_oe))) else $error("mdio moved while mdc high"); // R7
  AST_PREAMBLE_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && (idx_q < IW'(PRE_LEN))) |-> (mdio_oe && mdio_o)) else $error("preamble bit not one"); // R3
  AST_START_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !act_q) else $error("start while active"); // R2
endmodule

// File: rtl/mdio_cmd_master.sv
module mdio_cmd_master
  import mdio_cmd_pkg::*;
#(
  parameter int DIV_HALF = 4,
  parameter int PRE_LEN  = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  logic [CMD_W-1:0]  cmd_q;
  logic              launch;
  logic              eng_active;
  logic              eng_done;
  logic              eng_rd;
  logic [DATA_W-1:0] eng_data;
  logic              rise_tick;
  logic              fall_tick;

  assign launch    = reg_wr && !cmd_q[GO_BIT] && reg_wdata[GO_BIT];
  assign reg_rdata = cmd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= '0;
    end else if (reg_wr && !cmd_q[GO_BIT]) begin
      cmd_q <= reg_wdata;
    end else if (eng_done) begin
      cmd_q[GO_BIT] <= 1'b0;
      if (eng_rd) cmd_q[DATA_W-1:0] <= eng_data;
    end
  end

  mdio_clk_div #(.DIV_HALF(DIV_HALF)) i_div (
    .clk(clk), .rst_n(rst_n), .en(eng_active),
    .mdc(mdc), .rise_tick(rise_tick), .fall_tick(fall_tick)
  );

  mdio_frame_engine #(.PRE_LEN(PRE_LEN)) i_eng (
    .clk(clk), .rst_n(rst_n), .start(launch), .cmd(reg_wdata),
    .mdc(mdc), .rise_tick(rise_tick), .fall_tick(fall_tick),
    .mdio_i(mdio_i), .active(eng_active), .done(eng_done),
    .done_rd(eng_rd), .rd_data(eng_data),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe)
  );

  AST_BUSY_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && cmd_q[GO_BIT]) |=> (cmd_q[30:DATA_W] == $past(cmd_q[30:DATA_W]))) else $error("write taken while busy"); // R2
  AST_DONE_CLEARS_GO: assert property (@(posedge clk) disable iff (!rst_n)
    eng_done |=> !cmd_q[GO_BIT]) else $error("go bit not cleared"); // R1
  AST_LAUNCH_SETS_GO: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> (cmd_q[GO_BIT] && eng_active)) else $error("launch did not set busy"); // R1
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_q[GO_BIT] |-> (!mdio_oe && !mdc)) else $error("pins active while idle"); // R7
endmodule

// File: tb/test_mdio_cmd_master.sv
module test_mdio_cmd_master;
  localparam int CLK_PERIOD = 10;
  localparam int DIV_HALF   = 4;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i_r = 1'b1;

  int checks = 0;
  int errors = 0;

  // PHY model state (written only by the clocked block below)
  logic        mdc_d = 1'b0;
  int          ridx = 0;
  logic [63:0] cap_o = '0;
  logic [63:0] cap_oe = '0;
  int          per_cnt = 0;
  int          last_per = 0;
  logic [15:0] phy_val = 16'h0000;

  always #(CLK_PERIOD/2) clk = ~clk;

  mdio_cmd_master #(.DIV_HALF(DIV_HALF), .PRE_LEN(32)) i_mdio_cmd_master (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .mdio_i(mdio_i_r)
  );

  // Behavioural PHY: observes pins, drives data bits 48..63 of every frame
  always @(posedge clk) begin
    mdc_d <= mdc;
    per_cnt <= per_cnt + 1;
    if (!reg_rdata[31]) begin
      ridx <= 0;
      mdio_i_r <= 1'b1;
    end else if (mdc && !mdc_d) begin
      if (ridx < 64) begin
        cap_o[63-ridx]  <= mdio_o;
        cap_oe[63-ridx] <= mdio_oe;
      end
      ridx <= ridx + 1;
      last_per <= per_cnt;
      per_cnt <= 1;
    end else if (!mdc && mdc_d) begin
      if (ridx >= 48 && ridx <= 63) mdio_i_r <= phy_val[63-ridx];
      else mdio_i_r <= 1'b1;
    end
  end

  initial begin
    for (int i = 0; i < WATCHDOG; i++) @(posedge clk);
    $display("FAIL watchdog: run hung, actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors + 1);
    $finish;
  end

  task automatic check(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [1:0] st, input logic [1:0] op,
                                     input logic [4:0] phy, input logic [4:0] rg,
                                     input logic [15:0] d);
    return {1'b1, 1'b0, rg, phy, op, st, d};
  endfunction

  function automatic logic [63:0] exp_frame(input logic [31:0] w);
    return {32'hFFFF_FFFF, w[17:16], w[19:18], w[24:20], w[29:25], 2'b10, w[15:0]};
  endfunction

  task automatic write_reg(input logic [31:0] w);
    @(negedge clk);
    reg_wr = 1'b1;
    reg_wdata = w;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic wait_idle(input string tag);
    int n = 0;
    while (reg_rdata[31] && n < 2000) begin
      @(negedge clk);
      n++;
    end
    check(!reg_rdata[31], tag, 64'(reg_rdata), 64'(0));
  endtask

  task automatic run_cmd(input logic [31:0] w, input string tag);
    write_reg(w);
    check(reg_rdata[31] == 1'b1, {tag, " R1 busy"}, 64'(reg_rdata[31]), 64'(1));
    wait_idle({tag, " R1 done"});
  endtask

  task automatic check_write_frame(input logic [31:0] w, input string tag);
    check(cap_o == exp_frame(w), {tag, " R3 R4 frame"}, cap_o, exp_frame(w));
    check(cap_oe == '1, {tag, " R4 drive"}, cap_oe, '1);
    check(reg_rdata == {1'b0, w[30:0]}, {tag, " R6 readback"}, 64'(reg_rdata), 64'({1'b0, w[30:0]}));
  endtask

  task automatic check_read_frame(input logic [31:0] w, input logic [15:0] d, input string tag);
    check(cap_o[63:18] == exp_frame(w) >> 18, {tag, " R3 header"}, 64'(cap_o[63:18]), exp_frame(w) >> 18);
    check(cap_oe == {46'h3FFF_FFFF_FFFF, 18'h0}, {tag, " R5 release"}, cap_oe, {46'h3FFF_FFFF_FFFF, 18'h0});
    check(reg_rdata == {1'b0, w[30:16], d}, {tag, " R5 data"}, 64'(reg_rdata), 64'({1'b0, w[30:16], d}));
  endtask

  task automatic t_reset;
    check(reg_rdata == 32'h0, "R9 readback", 64'(reg_rdata), 64'(0));
    check(mdc == 1'b0, "R9 mdc", 64'(mdc), 64'(0));
    check(mdio_oe == 1'b0, "R9 oe", 64'(mdio_oe), 64'(0));
  endtask

  task automatic t_c22_write;
    logic [31:0] w = mk(2'b01, 2'b01, 5'h11, 5'h0A, 16'hA5C3);
    phy_val = 16'h0F0F;
    run_cmd(w, "c22 write");
    check_write_frame(w, "c22 write");
    check(last_per == 2*DIV_HALF, "R7 mdc period", 64'(last_per), 64'(2*DIV_HALF));
    check(mdc == 1'b0, "R7 mdc idle", 64'(mdc), 64'(0));
  endtask

  task automatic t_c22_read;
    logic [31:0] w = mk(2'b01, 2'b10, 5'h03, 5'h1F, 16'hFFFF);
    phy_val = 16'h8001;
    run_cmd(w, "c22 read");
    check_read_frame(w, 16'h8001, "c22 read");
    w = mk(2'b01, 2'b10, 5'h1C, 5'h02, 16'h0000);
    phy_val = 16'h7E5A;
    run_cmd(w, "c22 read2");
    check_read_frame(w, 16'h7E5A, "c22 read2");
  endtask

  task automatic t_c45;
    logic [31:0] wa = mk(2'b00, 2'b00, 5'h05, 5'h1E, 16'h1234);
    logic [31:0] ww = mk(2'b00, 2'b01, 5'h05, 5'h1E, 16'hBEEF);
    logic [31:0] wr = mk(2'b00, 2'b11, 5'h05, 5'h1E, 16'h0000);
    phy_val = 16'h0000;
    run_cmd(wa, "R8 c45 addr");
    check_write_frame(wa, "R8 c45 addr");
    run_cmd(ww, "R8 c45 write");
    check_write_frame(ww, "R8 c45 write");
    run_cmd(wa, "R8 c45 addr2");
    phy_val = 16'hC0DE;
    run_cmd(wr, "R8 c45 read");
    check_read_frame(wr, 16'hC0DE, "R8 c45 read");
  endtask

  task automatic t_busy_ignore;
    logic [31:0] wa = mk(2'b01, 2'b01, 5'h0C, 5'h07, 16'h5AA5);
    logic [31:0] wb = mk(2'b00, 2'b11, 5'h13, 5'h18, 16'hFFFF);
    phy_val = 16'h3333;
    write_reg(wa);
    repeat (60) @(negedge clk);
    write_reg(wb);
    check(reg_rdata == wa, "R2 readback while busy", 64'(reg_rdata), 64'(wa));
    write_reg(32'h0000_0000);
    check(reg_rdata == wa, "R2 clear write ignored", 64'(reg_rdata), 64'(wa));
    wait_idle("R2 done");
    check_write_frame(wa, "R2 frame");
    repeat (20) @(negedge clk);
    check(reg_rdata[31] == 1'b0 && mdio_oe == 1'b0, "R2 no second frame", 64'({reg_rdata[31], mdio_oe}), 64'(0));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_c22_write();
    t_c22_read();
    t_c45();
    t_busy_ignore();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule